// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Port

This block is the interface between an interrupt controller and one CPU. It takes in two signals: the vector of peripheral sources that the distributor has already routed to this CPU, and a single summary line that goes high when an inter-processor doorbell is pending for this CPU. It also keeps one mask bit per source number in a private register, and that bit is local to this CPU. From these inputs it drives one level-sensitive interrupt line to the CPU. It also answers reads of an acknowledge register with the number of the source the CPU should service.

Software never writes the mask as a bit vector. To block a source, it writes that source's number to the set-mask offset. To unblock it, it writes the number to the clear-mask offset. Source number 0 stands for the doorbell summary. Writing 0 to the clear-mask offset therefore lets doorbells reach the CPU. When more than one source qualifies, the lowest peripheral number wins. The doorbell code 0 is returned only when no peripheral source qualifies. A code of all ones in the 10-bit field (1023) means nothing is pending.

Top module: `cpu_irq_ack_port`

## Requirements
- R1: After reset every mask bit (sources 0 to NUM_SRC-1) is 1. While in reset, and right after it, cpuIrq is 0 even when every pending input and dbellIn are high. rdValid is 0 during reset.
- R2: A write of value N (N < NUM_SRC) to offset 0x48 sets mask bit N. From the next cycle on, source N no longer drives cpuIrq and is never returned by an acknowledge read.
- R3: A write of value N (N < NUM_SRC) to offset 0x4C clears mask bit N. Writing N = 0 to it unmasks the doorbell summary.
- R4: A write whose full 32-bit value is NUM_SRC or more changes no mask bit. So does a write to any offset other than 0x48 and 0x4C.
- R5: A read raises rdValid for exactly the following cycle. For a read at offset 0x44, rdData[9:0] then holds the lowest-numbered source in 1..NUM_SRC-1 that is pending and unmasked, and rdData[31:10] is 0. A read at any other offset returns 0.
- R6: When no peripheral source qualifies, dbellIn is high and mask bit 0 is clear, an acknowledge read returns 0.
- R7: When neither a peripheral source nor the doorbell qualifies, an acknowledge read returns 1023.
- R8: cpuIrq is the combinational OR of all pending, unmasked sources and the unmasked doorbell. It is high exactly when an acknowledge read would not return 1023, and it follows changes on pendIn in the same cycle.
- R9: An acknowledge read in the same cycle as a mask write returns the selection made with the mask as it was before that write.
- R10: An acknowledge read has no side effect. Repeated reads with unchanged inputs return the same number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pendIn | input | NUM_SRC-1 | Routed pending sources 1..NUM_SRC-1 (bit index is the source number) |
| dbellIn | input | 1 | Doorbell summary pending for this CPU |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write offset |
| wrData | input | DATA_W | Write value (source number) |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Read offset |
| rdData | output | DATA_W | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| cpuIrq | output | 1 | Interrupt line to the CPU |

## Verification
The two functions that can land in the same cycle are a mask write and an acknowledge read. The read and write channels are separate, so one cycle can both block or unblock a source and ask which source wins. The bench provokes this on purpose with directed cycles: one masks the currently winning source while reading, and one unmasks a lower source while reading. The random phase also produces such cycles often. The result is judged correct when the returned number matches a bench model evaluated on the mask from before the write, while cpuIrq and the following read show the mask after the write.

// File: rtl/cpu_irq_ack_pkg.sv
package cpu_irq_ack_pkg;
  // width of the source number field in the acknowledge word
  localparam int ID_BITS = 10;
  localparam logic [ID_BITS-1:0] SPURIOUS_ID = '1;

  typedef struct packed {
    logic               setMask;
    logic               clrMask;
    logic [ID_BITS-1:0] idx;
    logic               ackRd;
    logic               anyRd;
  } ctrl_strobe_t;
endpackage

// File: rtl/cpu_irq_ack_ctrl.sv
module cpu_irq_ack_ctrl
  import cpu_irq_ack_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter logic [ADDR_W-1:0] ACK_OFS = 'h44,
  parameter logic [ADDR_W-1:0] SET_OFS = 'h48,
  parameter logic [ADDR_W-1:0] CLR_OFS = 'h4C
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctrl_strobe_t      strb
);
  logic idxOk;

  always_comb begin
    idxOk        = (wrData < DATA_W'(NUM_SRC));
    strb.setMask = wrEn && idxOk && (wrAddr == SET_OFS);
    strb.clrMask = wrEn && idxOk && (wrAddr == CLR_OFS);
    strb.idx     = wrData[ID_BITS-1:0];
    strb.ackRd   = rdEn && (rdAddr == ACK_OFS);
    strb.anyRd   = rdEn;
  end
endmodule

// File: rtl/cpu_irq_ack_dp.sv
module cpu_irq_ack_dp
  import cpu_irq_ack_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:1] pendIn,
  input  logic               dbellIn,
  input  ctrl_strobe_t       strb,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid,
  output logic               cpuIrq
);
  localparam int PAD_W = DATA_W - ID_BITS;

  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:1] liveSrc;
  logic [NUM_SRC-1:1] beforeHit;   // a lower source already qualifies
  logic               dbLive;
  logic [ID_BITS-1:0] selId;

  // per-source mask bit, index written by software
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        maskQ[i] <= 1'b1;
      else if (strb.setMask && strb.idx == ID_BITS'(i))
        maskQ[i] <= 1'b1;
      else if (strb.clrMask && strb.idx == ID_BITS'(i))
        maskQ[i] <= 1'b0;
    end

    assert_set_bit_R2 : assert property (@(posedge clk) disable iff (!rstN)
      (strb.setMask && strb.idx == ID_BITS'(i)) |=> maskQ[i]);
    assert_clr_bit_R3 : assert property (@(posedge clk) disable iff (!rstN)
      (strb.clrMask && strb.idx == ID_BITS'(i)) |=> !maskQ[i]);
  end

  // qualified sources and a lowest-first priority chain
  for (genvar i = 1; i < NUM_SRC; i++) begin : g_live
    assign liveSrc[i] = pendIn[i] && !maskQ[i];
    if (i == 1) begin : g_first
      assign beforeHit[i] = 1'b0;
    end else begin : g_rest
      assign beforeHit[i] = beforeHit[i-1] || liveSrc[i-1];
    end
  end

  assign dbLive = dbellIn && !maskQ[0];

  always_comb begin
    selId = dbLive ? '0 : SPURIOUS_ID;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (liveSrc[i] && !beforeHit[i])
        selId = ID_BITS'(i);
    end
  end

  assign cpuIrq = (|liveSrc) || dbLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.anyRd;
      rdData  <= strb.ackRd ? {{PAD_W{1'b0}}, selId} : '0;
    end
  end

  // R1: mask comes out of reset fully set
  assert_reset_mask_R1 : assert property (@(posedge clk) !rstN |=> (&maskQ));
  // R8: line high exactly when the encoder finds something
  assert_irq_vs_sel_R8 : assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq == (selId != SPURIOUS_ID));
  // R5: a read is answered on the next cycle
  assert_rd_latency_R5 : assert property (@(posedge clk) disable iff (!rstN)
    strb.anyRd |=> rdValid);
  assert_rd_pad_R5 : assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData[DATA_W-1:ID_BITS] == '0));
endmodule

// File: rtl/cpu_irq_ack_port.sv
module cpu_irq_ack_port
  import cpu_irq_ack_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:1] pendIn,
  input  logic               dbellIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid,
  output logic               cpuIrq
);
  ctrl_strobe_t strb;

  cpu_irq_ack_ctrl #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb)
  );

  cpu_irq_ack_dp #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pendIn(pendIn), .dbellIn(dbellIn),
    .strb(strb), .rdData(rdData), .rdValid(rdValid), .cpuIrq(cpuIrq)
  );
endmodule

// File: tb/sim_cpu_irq_ack_port.sv
module sim_cpu_irq_ack_port;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;
  localparam logic [11:0] A_ACK = 12'h044;
  localparam logic [11:0] A_SET = 12'h048;
  localparam logic [11:0] A_CLR = 12'h04C;

  logic        clk = 1'b0;
  logic        rstN;
  logic [NS-1:1] pendIn;
  logic        dbellIn;
  logic        wrEn, rdEn;
  logic [11:0] wrAddr, rdAddr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        rdValid, cpuIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  logic [NS-1:0] mdlMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_irq_ack_port u0 (
    .clk(clk), .rstN(rstN), .pendIn(pendIn), .dbellIn(dbellIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .rdValid(rdValid), .cpuIrq(cpuIrq)
  );

  function automatic logic [31:0] expSel(input logic [NS-1:0] m,
                                         input logic [NS-1:1] p, input logic d);
    for (int i = 1; i < NS; i++)
      if (p[i] && !m[i]) return 32'(i);
    if (d && !m[0]) return 32'd0;
    return 32'd1023;
  endfunction

  function automatic logic expIrq(input logic [NS-1:0] m,
                                  input logic [NS-1:1] p, input logic d);
    return expSel(m, p, d) != 32'd1023;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at negedge, check at the following negedge
  task automatic step(input bit wE, input logic [11:0] wA, input logic [31:0] wD,
                      input bit rE, input logic [11:0] rA,
                      input logic [NS-1:1] p, input logic d, input string tag);
    logic [31:0] expRd;
    wrEn = wE; wrAddr = wA; wrData = wD;
    rdEn = rE; rdAddr = rA; pendIn = p; dbellIn = d;
    expRd = (rA == A_ACK) ? expSel(mdlMask, p, d) : 32'd0;
    if (wE && wD < NS) begin
      if (wA == A_SET) mdlMask[wD[4:0]] = 1'b1;
      else if (wA == A_CLR) mdlMask[wD[4:0]] = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " rdValid"}, {31'd0, rdValid}, {31'd0, rE});
    if (rE) check({tag, " rdData"}, rdData, expRd);
    check({tag, " cpuIrq"}, {31'd0, cpuIrq}, {31'd0, expIrq(mdlMask, p, d)});
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic ackRead(input logic [NS-1:1] p, input logic d, input string tag);
    step(1'b0, A_ACK, 32'd0, 1'b1, A_ACK, p, d, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFails);
      $finish;
    end
  end

  initial begin
    logic [NS-1:1] p;
    logic [31:0] v;
    mdlMask = '1;
    rstN = 1'b0; wrEn = 0; rdEn = 0; wrAddr = 0; rdAddr = 0; wrData = 0;
    pendIn = '1; dbellIn = 1'b1;
    repeat (3) @(negedge clk);
    // R1: in reset, everything pending but line low
    check("R1 irq in reset", {31'd0, cpuIrq}, 32'd0);
    check("R1 rdValid in reset", {31'd0, rdValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {31'd0, cpuIrq}, 32'd0);
    ackRead('1, 1'b1, "R7");                         // all masked -> 1023

    // R3 unmask source 3, R5 it is reported
    step(1'b1, A_CLR, 32'd3, 1'b0, A_ACK, '0, 1'b0, "R3");
    p = '0; p[3] = 1'b1;
    ackRead(p, 1'b0, "R5");
    step(1'b1, A_CLR, 32'd7, 1'b0, A_ACK, p, 1'b0, "R3");
    p[7] = 1'b1;
    ackRead(p, 1'b0, "R5");                          // lowest wins: 3
    step(1'b1, A_SET, 32'd3, 1'b0, A_ACK, p, 1'b0, "R2");
    ackRead(p, 1'b0, "R2");                          // 3 blocked -> 7

    // R6 doorbell
    step(1'b1, A_CLR, 32'd0, 1'b0, A_ACK, p, 1'b1, "R3");
    ackRead(p, 1'b1, "R6");                          // peripheral first: 7
    ackRead('0, 1'b1, "R6");                         // doorbell only: 0
    ackRead('0, 1'b0, "R7");                         // nothing: 1023

    // R4 ignored writes: out-of-range index and other offset
    step(1'b1, A_SET, 32'd40, 1'b0, A_ACK, p, 1'b0, "R4");
    step(1'b1, A_SET, 32'h0001_0007, 1'b0, A_ACK, p, 1'b0, "R4");
    step(1'b1, 12'h050, 32'd7, 1'b0, A_ACK, p, 1'b0, "R4");
    ackRead(p, 1'b0, "R4");                          // still 7

    // R9 same-cycle write and read: old mask used
    step(1'b1, A_SET, 32'd7, 1'b1, A_ACK, p, 1'b0, "R9");
    ackRead(p, 1'b0, "R9");                          // now 1023
    step(1'b1, A_CLR, 32'd3, 1'b1, A_ACK, p, 1'b0, "R9"); // old: 1023
    // R10 repeated reads
    ackRead(p, 1'b0, "R10");
    ackRead(p, 1'b0, "R10");
    // R5 other offset reads zero
    step(1'b0, A_ACK, 32'd0, 1'b1, 12'h040, p, 1'b0, "R5");

    // R8 combinational follow of pendIn mid-cycle
    pendIn = '0; #1;
    check("R8 irq drop", {31'd0, cpuIrq}, 32'd0);
    pendIn[3] = 1'b1; #1;
    check("R8 irq rise", {31'd0, cpuIrq}, 32'd1);
    @(negedge clk);

    // random phase, fixed seed
    v = $urandom(1234);
    for (int n = 0; n < 600; n++) begin
      bit wE, rE, d;
      logic [11:0] wA, rA;
      logic [31:0] wD;
      for (int i = 1; i < NS; i++) p[i] = ($urandom_range(0, 7) == 0);
      d  = $urandom_range(0, 1);
      wE = $urandom_range(0, 1);
      wA = $urandom_range(0, 1) ? A_SET : A_CLR;
      if ($urandom_range(0, 9) == 0) wA = 12'h030;
      wD = 32'($urandom_range(0, 35));
      rE = $urandom_range(0, 1);
      rA = ($urandom_range(0, 7) == 0) ? 12'h04C : A_ACK;
      step(wE, wA, wD, rE, rA, p, d, "R5");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule